// File: doc/BRIEF.md
# Cross-Mask Similarity Feature Extractor

This block takes a stream of 8-bit grey pixels in raster order and, for every pixel of the frame, produces a pair of 4-bit similarity words. The words describe a plus-shaped neighbourhood around the pixel, which is the centre. One word covers the column through the centre: the pixels two and one rows above and one and two rows below. The other word covers the row through the centre: the pixels two and one columns to the left and one and two columns to the right. A bit is set when the neighbour's grey level is within a programmable distance of the centre's grey level. A downstream edge matcher can then classify each centre by looking only at these bit patterns.

Four line memories hold the earlier rows. Both the pixel input and the feature output use a valid/ready handshake. Each output beat carries the centre's row and column and a border flag. Centres too close to the frame edge to have a full cross get the border flag and all-ones words. Frame width, frame height and threshold are set through a small write-only register port between frames. Centres that are still pending when the last pixel enters are flushed out without further input.

Top module: `xmask_feature_extract`

## Requirements
- R1: A similarity bit is 1 exactly when the absolute difference between the neighbour's grey value and the centre's grey value is less than or equal to the threshold. A difference of zero therefore gives 1 even with threshold 0.
- R2: Bits of `o_vert` for a non-border centre at (r,c): bit 0 compares (r-2,c), bit 1 compares (r-1,c), bit 2 compares (r+1,c), bit 3 compares (r+2,c).
- R3: Bits of `o_horz` for a non-border centre at (r,c): bit 0 compares (r,c-2), bit 1 compares (r,c-1), bit 2 compares (r,c+1), bit 3 compares (r,c+2).
- R4: A centre with row < 2, row > height-3, column < 2 or column > width-3 is emitted with `o_border` = 1 and both words equal to 4'hF. Every other centre has `o_border` = 0.
- R5: Each frame yields exactly width × height output beats in raster order. The beats start at row 0, column 0, and `o_row`/`o_col` give the centre of each beat. No beat follows the last one of a frame.
- R6: While `o_valid` is 1 and `o_ready` is 0, every output field stays unchanged on the next cycle. Random stalls on either side lose or duplicate no pixel.
- R7: After the last pixel of a frame is accepted, the pending beats are produced without further input. `in_ready` stays 0 until the last one has been loaded, and then returns to 1.
- R8: Configuration writes with `cfg_wr` = 1 select a register by `cfg_sel`: 0 sets width, 1 sets height, 2 sets threshold, and 3 is ignored. After reset the values are width 481, height 321 and threshold 20. A new threshold applies to the next frame.
- R9: After reset `o_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 width, 1 height, 2 threshold |
| cfg_data | input | CFG_DW | Write data, low bits used |
| in_valid | input | 1 | Pixel present |
| in_ready | output | 1 | Pixel accepted when high with in_valid |
| in_pix | input | PIX_W | Grey value |
| o_valid | output | 1 | Feature beat present |
| o_ready | input | 1 | Consumer takes the beat |
| o_vert | output | 4 | Column-arm similarity bits |
| o_horz | output | 4 | Row-arm similarity bits |
| o_border | output | 1 | Centre lies in the two-pixel frame margin |
| o_row | output | ROW_W | Centre row |
| o_col | output | COL_W | Centre column |

## Verification
Frames filled with values that straddle the threshold check the comparison itself. A two-level frame with threshold zero separates "less than" from "less than or equal". A vertical/horizontal gradient frame gives one arm all zeros and the other all ones, so swapped arms or reversed bit order show up at once. A full-width frame at the reset width and threshold confirms the reset configuration. A minimal 5×5 frame leaves a single interior centre. Random valid and ready duty cycles move the stalls through the line memories and through the flush tail, where lost, repeated or mis-coordinated beats would appear.

// File: rtl/xmf_pkg.sv
// Shared constants and types for the cross-mask similarity extractor.
// Assumes nothing beyond standard SystemVerilog packages.
package xmf_pkg;

    // Configuration register selector values
    typedef enum logic [1:0] {
        SEL_WIDTH  = 2'd0,
        SEL_HEIGHT = 2'd1,
        SEL_THRESH = 2'd2,
        SEL_NONE   = 2'd3
    } cfg_sel_e;

    // Neighbours per arm of the cross and stored earlier rows
    localparam int ARM_LEN    = 4;
    localparam int SPAN_LINES = 4;

endpackage

// File: rtl/xmf_cfg_regs.sv
// Holds frame width, frame height and similarity threshold.
// Assumes software writes only between frames; unused selector is ignored.
module xmf_cfg_regs
    import xmf_pkg::*;
#(
    parameter int CFG_DW     = 16,
    parameter int COL_W      = 10,
    parameter int ROW_W      = 10,
    parameter int PIX_W      = 8,
    parameter int RST_WIDTH  = 481,
    parameter int RST_HEIGHT = 321,
    parameter int RST_THR    = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_DW-1:0] cfg_data,
    output logic [COL_W-1:0]  width_q,
    output logic [ROW_W-1:0]  height_q,
    output logic [PIX_W-1:0]  thr_q
);

    // Register writes by selector, reset to the documented defaults
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q  <= COL_W'(RST_WIDTH);
            height_q <= ROW_W'(RST_HEIGHT);
            thr_q    <= PIX_W'(RST_THR);
        end else if (cfg_wr) begin
            case (cfg_sel_e'(cfg_sel))
                SEL_WIDTH:  width_q  <= cfg_data[COL_W-1:0];
                SEL_HEIGHT: height_q <= cfg_data[ROW_W-1:0];
                SEL_THRESH: thr_q    <= cfg_data[PIX_W-1:0];
                default:    ;
            endcase
        end
    end

endmodule

// File: rtl/xmf_line_store.sv
// Cascade of row memories: tap[i] returns the pixel i+1 rows above the
// incoming one at the addressed column; a write pushes each column down.
// Assumes at most one write per cycle and column < MAX_W.
module xmf_line_store #(
    parameter int PIX_W = 8,
    parameter int MAX_W = 512,
    parameter int LINES = 4,
    parameter int AW    = 9
) (
    input  logic                        clk,
    input  logic                        wr_en,
    input  logic [AW-1:0]               col,
    input  logic [PIX_W-1:0]            din,
    output logic [LINES-1:0][PIX_W-1:0] tap
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic [PIX_W-1:0] mem [MAX_W];
        logic [PIX_W-1:0] feed;

        if (i == 0) begin : g_head
            assign feed = din;
        end else begin : g_chain
            assign feed = tap[i-1];
        end

        assign tap[i] = mem[col];

        // Shift this column one row deeper on every accepted pixel
        always_ff @(posedge clk) begin
            if (wr_en) mem[col] <= feed;
        end
    end

endmodule

// File: rtl/xmf_similarity.sv
// Compares N neighbours against a centre value; a bit is set when the
// absolute difference does not exceed the threshold. Purely combinational.
module xmf_similarity #(
    parameter int PIX_W = 8,
    parameter int N     = 4
) (
    input  logic [PIX_W-1:0]          centre,
    input  logic [N-1:0][PIX_W-1:0]   neigh,
    input  logic [PIX_W-1:0]          thr,
    output logic [N-1:0]              similar
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic [PIX_W-1:0] diff;
        assign diff       = (centre >= neigh[i]) ? (centre - neigh[i]) : (neigh[i] - centre);
        assign similar[i] = (diff <= thr);
    end

endmodule

// File: rtl/xmask_feature_extract.sv
// Streams raster pixels, keeps four earlier rows and a short row history,
// and emits one similarity beat per pixel, lagging the input by two rows
// and two columns. Border centres carry a flag and all-ones words; the
// tail of each frame is flushed without input. Assumes width and height
// of at least 5 and configuration changes only between frames.
module xmask_feature_extract
    import xmf_pkg::*;
#(
    parameter int PIX_W      = 8,
    parameter int MAX_W      = 512,
    parameter int MAX_H      = 512,
    parameter int CFG_DW     = 16,
    parameter int RST_WIDTH  = 481,
    parameter int RST_HEIGHT = 321,
    parameter int RST_THR    = 20,
    localparam int COL_W     = $clog2(MAX_W + 1),
    localparam int ROW_W     = $clog2(MAX_H + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_DW-1:0] cfg_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PIX_W-1:0]  in_pix,
    output logic              o_valid,
    input  logic              o_ready,
    output logic [3:0]        o_vert,
    output logic [3:0]        o_horz,
    output logic              o_border,
    output logic [ROW_W-1:0]  o_row,
    output logic [COL_W-1:0]  o_col
);

    localparam int AW = $clog2(MAX_W);
    localparam logic [ROW_W:0] TWO_R = (ROW_W+1)'(2);
    localparam logic [COL_W:0] TWO_C = (COL_W+1)'(2);

    logic [COL_W-1:0] width_q;
    logic [ROW_W-1:0] height_q;
    logic [PIX_W-1:0] thr_q;

    logic [ROW_W-1:0] in_r, out_r;
    logic [COL_W-1:0] in_c, out_c;
    logic             flushing;

    logic [PIX_W-1:0]                    h1, h2, h3, h4;
    logic [ARM_LEN-1:0][PIX_W-1:0]       v1, v2, v_now, horz_nb;
    logic [SPAN_LINES-1:0][PIX_W-1:0]    tap;
    logic [ARM_LEN-1:0]                  vert_bits, horz_bits;

    logic out_ok, acc, emit_now, in_last, out_last, load, out_border;

    xmf_cfg_regs #(
        .CFG_DW(CFG_DW), .COL_W(COL_W), .ROW_W(ROW_W), .PIX_W(PIX_W),
        .RST_WIDTH(RST_WIDTH), .RST_HEIGHT(RST_HEIGHT), .RST_THR(RST_THR)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .width_q(width_q), .height_q(height_q), .thr_q(thr_q)
    );

    xmf_line_store #(
        .PIX_W(PIX_W), .MAX_W(MAX_W), .LINES(SPAN_LINES), .AW(AW)
    ) lines_i (
        .clk(clk), .wr_en(acc), .col(in_c[AW-1:0]), .din(in_pix), .tap(tap)
    );

    // Column at the input: rows R-4, R-3, R-1, R (R = incoming row)
    assign v_now   = {in_pix, tap[0], tap[2], tap[3]};
    // Row R-2 around column x-2: x-4, x-3, x-1, x
    assign horz_nb = {tap[1], h1, h3, h4};

    xmf_similarity #(.PIX_W(PIX_W), .N(ARM_LEN)) sim_vert_i (
        .centre(h2), .neigh(v2), .thr(thr_q), .similar(vert_bits)
    );

    xmf_similarity #(.PIX_W(PIX_W), .N(ARM_LEN)) sim_horz_i (
        .centre(h2), .neigh(horz_nb), .thr(thr_q), .similar(horz_bits)
    );

    // Handshake and sequencing conditions
    assign out_ok   = !o_valid || o_ready;
    assign in_ready = !flushing && out_ok;
    assign acc      = in_valid && in_ready;
    assign emit_now = (in_r > ROW_W'(2)) || ((in_r == ROW_W'(2)) && (in_c >= COL_W'(2)));
    assign in_last  = (in_r == height_q - 1'b1) && (in_c == width_q - 1'b1);
    assign out_last = (out_r == height_q - 1'b1) && (out_c == width_q - 1'b1);
    assign load     = (acc && emit_now) || (flushing && out_ok);

    // Margin test for the centre about to be loaded
    assign out_border = (out_r < ROW_W'(2)) || (out_c < COL_W'(2)) ||
                        (({1'b0, out_r} + TWO_R) >= {1'b0, height_q}) ||
                        (({1'b0, out_c} + TWO_C) >= {1'b0, width_q});

    // Input raster position and flush state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_r     <= '0;
            in_c     <= '0;
            flushing <= 1'b0;
        end else begin
            if (acc) begin
                if (in_c == width_q - 1'b1) begin
                    in_c <= '0;
                    in_r <= in_last ? '0 : in_r + 1'b1;
                end else begin
                    in_c <= in_c + 1'b1;
                end
                if (in_last) flushing <= 1'b1;
            end else if (flushing && out_ok && out_last) begin
                flushing <= 1'b0;
            end
        end
    end

    // Row history and delayed columns for the cross window
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h1 <= '0; h2 <= '0; h3 <= '0; h4 <= '0;
            v1 <= '0; v2 <= '0;
        end else if (acc) begin
            h4 <= h3; h3 <= h2; h2 <= h1; h1 <= tap[1];
            v2 <= v1; v1 <= v_now;
        end
    end

    // Output register and centre raster position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid  <= 1'b0;
            o_vert   <= '0;
            o_horz   <= '0;
            o_border <= 1'b0;
            o_row    <= '0;
            o_col    <= '0;
            out_r    <= '0;
            out_c    <= '0;
        end else if (load) begin
            o_valid  <= 1'b1;
            o_vert   <= out_border ? 4'hF : vert_bits;
            o_horz   <= out_border ? 4'hF : horz_bits;
            o_border <= out_border;
            o_row    <= out_r;
            o_col    <= out_c;
            if (out_c == width_q - 1'b1) begin
                out_c <= '0;
                out_r <= out_last ? '0 : out_r + 1'b1;
            end else begin
                out_c <= out_c + 1'b1;
            end
        end else if (o_ready) begin
            o_valid <= 1'b0;
        end
    end

    // R4: a flagged beat always carries all-ones words
    a_r4_border_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && o_border) |-> (o_vert == 4'hF && o_horz == 4'hF));

    // R6: a stalled beat is held unchanged
    a_r6_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_ready) |=> (o_valid && $stable({o_vert, o_horz, o_border, o_row, o_col})));

    // R5: emitted coordinates lie inside the configured frame
    a_r5_coord_range: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid |-> (o_col < width_q && o_row < height_q));

    // R7: beats produced during the flush tail are all margin centres
    a_r7_flush_is_border: assert property (@(posedge clk) disable iff (!rst_n)
        (flushing && load) |=> o_border);

    // R7: no pixel is taken while the tail is draining
    a_r7_no_accept_in_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (flushing && !out_last) |=> !acc);

endmodule

// File: tb/xmask_feature_extract_tb_top.sv
// Self-checking bench: random and directed frames against a bench model.
module xmask_feature_extract_tb_top;

    localparam int ROW_W = 10;
    localparam int COL_W = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [1:0]        cfg_sel = 2'd0;
    logic [15:0]       cfg_data = '0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [7:0]        in_pix = '0;
    logic              o_valid;
    logic              o_ready = 1'b0;
    logic [3:0]        o_vert, o_horz;
    logic              o_border;
    logic [ROW_W-1:0]  o_row;
    logic [COL_W-1:0]  o_col;

    int total = 0;
    int bad   = 0;
    logic [7:0] img [0:4095];

    always #5 clk = ~clk;

    xmask_feature_extract dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .in_valid(in_valid), .in_ready(in_ready),
        .in_pix(in_pix), .o_valid(o_valid), .o_ready(o_ready),
        .o_vert(o_vert), .o_horz(o_horz), .o_border(o_border),
        .o_row(o_row), .o_col(o_col)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input int sel, input int val);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = 2'(sel); cfg_data = 16'(val);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    function automatic bit near(input int a, input int b, input int thr);
        int d;
        d = (a > b) ? a - b : b - a;
        return d <= thr;
    endfunction

    // Expected {horz, vert} for an interior centre
    function automatic logic [7:0] expect_bits(input int r, input int c, input int w, input int thr);
        logic [7:0] e;
        int ctr;
        ctr  = img[r*w+c];
        e[0] = near(img[(r-2)*w+c], ctr, thr);
        e[1] = near(img[(r-1)*w+c], ctr, thr);
        e[2] = near(img[(r+1)*w+c], ctr, thr);
        e[3] = near(img[(r+2)*w+c], ctr, thr);
        e[4] = near(img[r*w+c-2], ctr, thr);
        e[5] = near(img[r*w+c-1], ctr, thr);
        e[6] = near(img[r*w+c+1], ctr, thr);
        e[7] = near(img[r*w+c+2], ctr, thr);
        return e;
    endfunction

    task automatic run_frame(input int w, input int h, input int thr, input int pv,
                             input int pr, input string vtag, input string htag);
        int n;
        int ptr;
        int idx;
        int cyc;
        bit hold;
        logic [28:0] held;
        n = w*h; ptr = 0; idx = 0; cyc = 0; hold = 0; held = '0;
        while (idx < n && cyc < 40000) begin
            @(negedge clk);
            cyc++;
            if (hold)
                chk(o_valid && ({o_vert, o_horz, o_border, o_row, o_col} == held),
                    "R6 stalled beat changed", int'({o_row, o_col}), int'(held[19:0]));
            in_valid = (ptr < n) && ($urandom_range(0, 99) < pv);
            in_pix   = (ptr < n) ? img[ptr] : 8'd0;
            o_ready  = ($urandom_range(0, 99) < pr);
            #1;
            if (ptr == n && (n - idx - int'(o_valid)) > 0)
                chk(!in_ready, "R7 in_ready during flush", int'(in_ready), 0);
            if (in_valid && in_ready) ptr++;
            if (o_valid && o_ready) begin
                int r, c;
                bit bd;
                logic [7:0] e;
                r  = idx / w; c = idx % w;
                bd = (r < 2) || (r > h-3) || (c < 2) || (c > w-3);
                e  = bd ? 8'hFF : expect_bits(r, c, w, thr);
                chk(int'(o_row) == r && int'(o_col) == c, "R5 coordinate",
                    int'(o_row)*1000 + int'(o_col), r*1000 + c);
                chk(o_border == bd, "R4 border flag", int'(o_border), int'(bd));
                chk(o_vert == e[3:0], vtag, int'(o_vert), int'(e[3:0]));
                chk(o_horz == e[7:4], htag, int'(o_horz), int'(e[7:4]));
                idx++;
            end
            hold = o_valid && !o_ready;
            held = {o_vert, o_horz, o_border, o_row, o_col};
        end
        chk(idx == n, "R5 beat count (frame watchdog)", idx, n);
        @(negedge clk);
        in_valid = 1'b0; o_ready = 1'b1;
        #1;
        chk(!o_valid, "R5 no extra beat", int'(o_valid), 0);
        chk(in_ready, "R7 in_ready after flush", int'(in_ready), 1);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!o_valid, "R9 reset o_valid", int'(o_valid), 0);
        chk(in_ready, "R9 reset in_ready", int'(in_ready), 1);

        // Reset width 481 and threshold 20; only height written
        for (int i = 0; i < 481*5; i++) img[i] = 8'(100 + $urandom_range(0, 50));
        cfg_write(1, 5);
        run_frame(481, 5, 20, 80, 80, "R8 default threshold vert", "R8 default threshold horz");

        // Threshold 0 with two levels: equality is similar
        for (int i = 0; i < 9*7; i++) img[i] = 8'(50 + $urandom_range(0, 1));
        cfg_write(0, 9); cfg_write(1, 7); cfg_write(2, 0);
        run_frame(9, 7, 0, 70, 70, "R1 threshold zero vert", "R1 threshold zero horz");

        // Ignored selector must not alter threshold
        cfg_write(3, 200);

        // Gradient: rows differ by 30, columns by 3, threshold 10
        for (int r = 0; r < 7; r++)
            for (int c = 0; c < 8; c++) img[r*8+c] = 8'(r*30 + c*3);
        cfg_write(0, 8); cfg_write(2, 10);
        run_frame(8, 7, 10, 90, 90, "R2 vertical arm", "R3 horizontal arm");

        // Wide random frame with heavy back-pressure
        for (int i = 0; i < 16*10; i++) img[i] = 8'(120 + $urandom_range(0, 60));
        cfg_write(0, 16); cfg_write(1, 10); cfg_write(2, 30);
        run_frame(16, 10, 30, 60, 30, "R1 random vert", "R3 random horz");

        // Minimal frame, maximum threshold
        for (int i = 0; i < 25; i++) img[i] = 8'($urandom_range(0, 255));
        cfg_write(0, 5); cfg_write(1, 5); cfg_write(2, 255);
        run_frame(5, 5, 255, 50, 95, "R2 minimal frame", "R3 minimal frame");

        // Full-speed frame, threshold just at a known difference
        for (int i = 0; i < 12*6; i++) img[i] = 8'(($urandom_range(0, 1) == 1) ? 90 : 98);
        cfg_write(0, 12); cfg_write(1, 6); cfg_write(2, 8);
        run_frame(12, 6, 8, 100, 100, "R1 diff equals threshold", "R1 diff equals threshold");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule